// File: doc/BRIEF.md
# Complementary PWM Dead-Band Inserter

This block turns a single raw PWM level into a pair of complementary gate-drive signals for a half bridge. The true drive follows the raw signal and the complementary drive follows its inverse. Each drive has its own timer that keeps it low for a fixed number of clock cycles after its raw level goes high. As a result, the drive that is turning on always waits until the other drive has been off for the full dead band. Turn-off is not delayed.

A 2-bit operating mode and a 4-bit duty code can force both drives low. This happens in the idle mode, and in the DC mode when the duty code is zero. Generating the PWM waveform is done elsewhere. The dead-band length in cycles is a parameter. The default is 25 cycles, which is 500 ns at 50 MHz. All inputs and outputs are plain level signals with no handshake, because the block is a level follower and has no stream to stall.

Top module: `pwm_deadband`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, both drive outputs are low.
- R2: `drv_hi` goes high at the (DEAD_CYC+1)-th consecutive rising clock edge at which the effective raw level (`pwm_in`, not forced) is high. It goes low at the first edge at which that level is low.
- R3: `drv_lo` behaves the same way as R2 with respect to the inverse of `pwm_in`. It rises DEAD_CYC+1 edges after `pwm_in` goes low and falls at the first edge after `pwm_in` goes high.
- R4: If a raw level pulse lasts DEAD_CYC edges or fewer, the corresponding drive stays low for the whole pulse.
- R5: `drv_hi` and `drv_lo` are never high in the same cycle.
- R6: Mode code 2'b00 (idle) forces both drives low from the first edge after it is applied, whatever `pwm_in` and `duty` are.
- R7: Mode code 2'b01 (DC) with duty code 4'b0000 forces both drives low. Mode 2'b01 with any nonzero duty code passes the signals normally.
- R8: Mode codes 2'b10 and 2'b11 pass the signals normally, even when the duty code is zero.
- R9: When a force condition ends while the raw level for a drive is high, that drive still waits the full dead band of R2/R3 before it rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw PWM level |
| mode | input | 2 | Operating mode: 00 idle, 01 DC, 10 AC, 11 self-test |
| duty | input | 4 | DC duty code; only 0000 is decoded here |
| drv_hi | output | 1 | True gate drive |
| drv_lo | output | 1 | Complementary gate drive |

## Verification
A falling drive is due one clock edge after its raw level drops or a force condition appears, because it passes through one output register. A rising drive is due exactly DEAD_CYC+1 edges after its raw level goes high and stays high. The bench changes inputs on the falling clock edge and samples on falling edges. It checks that a drive is still low after DEAD_CYC edges and high after DEAD_CYC+1 edges, so an error of one cycle in either direction is caught. Short pulses are driven for exactly DEAD_CYC edges, which is the longest pulse that must still be suppressed.

// File: rtl/pwm_deadband_pkg.sv
package pwm_deadband_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'b00,
    MODE_DC   = 2'b01,
    MODE_AC   = 2'b10,
    MODE_TEST = 2'b11
  } op_mode_t;

  localparam int DUTY_W = 4;

endpackage

// File: rtl/pwm_force_decode.sv
module pwm_force_decode
  import pwm_deadband_pkg::*;
#(
  parameter int DW = DUTY_W
) (
  input  logic [1:0]    mode,
  input  logic [DW-1:0] duty,
  output logic          force_low
);

  op_mode_t m;

  always_comb begin
    m = op_mode_t'(mode);
    unique case (m)
      MODE_IDLE: force_low = 1'b1;
      MODE_DC:   force_low = (duty == '0);
      default:   force_low = 1'b0;
    endcase
  end

endmodule

// File: rtl/pwm_db_channel.sv
module pwm_db_channel #(
  parameter int DEAD_CYC = 25,
  parameter bit INVERT   = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic force_low,
  output logic drv
);

  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC);

  logic          raw;
  logic [CW-1:0] cnt_q;
  logic          drv_q;

  assign raw = (INVERT ? ~pwm_in : pwm_in) & ~force_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= LOAD;
      drv_q <= 1'b0;
    end else if (!raw) begin
      cnt_q <= LOAD;
      drv_q <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      drv_q <= 1'b0;
    end else begin
      drv_q <= 1'b1;
    end
  end

  assign drv = drv_q;

  AST_FALL_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> !drv_q); // R2

  AST_RISE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_q) |-> ($past(raw, 1) && $past(raw, 2))); // R4

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LOAD); // R2

  initial begin
    AST_DEAD_POSITIVE: assert (DEAD_CYC >= 1); // R2
  end

endmodule

// File: rtl/pwm_deadband.sv
module pwm_deadband
  import pwm_deadband_pkg::*;
#(
  parameter int DEAD_CYC = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwm_in,
  input  logic [1:0]        mode,
  input  logic [DUTY_W-1:0] duty,
  output logic              drv_hi,
  output logic              drv_lo
);

  localparam int NCH = 2;

  logic           force_low;
  logic [NCH-1:0] drv_v;

  pwm_force_decode #(.DW(DUTY_W)) u_force (
    .mode      (mode),
    .duty      (duty),
    .force_low (force_low)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_db_channel #(
      .DEAD_CYC (DEAD_CYC),
      .INVERT   (g == 1)
    ) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_in    (pwm_in),
      .force_low (force_low),
      .drv       (drv_v[g])
    );
  end

  assign drv_hi = drv_v[0];
  assign drv_lo = drv_v[1];

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_hi && drv_lo)); // R5

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    force_low |=> (!drv_hi && !drv_lo)); // R6

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> (!drv_hi && !drv_lo)); // R6

  AST_DC_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && duty == '0) |=> (!drv_hi && !drv_lo)); // R7

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |-> (!drv_hi && !drv_lo)); // R1

endmodule

// File: tb/pwm_deadband_test.sv
module pwm_deadband_test;

  localparam int DEAD = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwm_in = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [3:0] duty = 4'h0;
  logic       drv_hi, drv_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_deadband #(.DEAD_CYC(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in),
    .mode(mode), .duty(duty), .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic hi_exp, input logic lo_exp);
    checks++;
    if (drv_hi !== hi_exp || drv_lo !== lo_exp) begin
      errors++;
      $display("FAIL %s: hi/lo actual=%b%b expected=%b%b at %0t",
               req, drv_hi, drv_lo, hi_exp, lo_exp, $time);
    end
  endtask

  // Settle with pwm low so drv_lo is fully on.
  task automatic settle_low();
    pwm_in = 1'b0;
    step(DEAD + 3);
  endtask

  task automatic t_reset();
    chk("R1", 1'b0, 1'b0);
    step(1);
    rst_n = 1'b1;
    step(1);
    chk("R1", 1'b0, 1'b0);
  endtask

  task automatic t_hi_edge();
    settle_low();
    chk("R3", 1'b0, 1'b1);
    pwm_in = 1'b1;
    step(1);
    chk("R3", 1'b0, 1'b0);
    step(DEAD - 1);
    chk("R2", 1'b0, 1'b0);
    step(1);
    chk("R2", 1'b1, 1'b0);
    pwm_in = 1'b0;
    step(1);
    chk("R2", 1'b0, 1'b0);
    step(DEAD - 1);
    chk("R3", 1'b0, 1'b0);
    step(1);
    chk("R3", 1'b0, 1'b1);
  endtask

  task automatic t_short_pulse();
    settle_low();
    pwm_in = 1'b1;
    for (int i = 0; i < DEAD; i++) begin
      step(1);
      chk("R4", 1'b0, 1'b0);
    end
    pwm_in = 1'b0;
    step(1);
    chk("R4", 1'b0, 1'b0);
    // short low gap suppresses drv_lo
    step(DEAD + 2);
    pwm_in = 1'b1;
    step(DEAD + 1);
    chk("R2", 1'b1, 1'b0);
    pwm_in = 1'b0;
    for (int i = 0; i < DEAD; i++) begin
      step(1);
      chk("R4", 1'b0, 1'b0);
    end
    pwm_in = 1'b1;
    step(1);
    chk("R4", 1'b0, 1'b0);
  endtask

  task automatic t_no_overlap();
    settle_low();
    for (int i = 0; i < 300; i++) begin
      pwm_in = ((i * 7) % 61) > 30;
      step(1);
      checks++;
      if (drv_hi && drv_lo) begin
        errors++;
        $display("FAIL R5: hi/lo actual=11 expected=not 11 at %0t", $time);
      end
    end
  endtask

  task automatic t_idle();
    settle_low();
    pwm_in = 1'b1;
    step(DEAD + 2);
    chk("R2", 1'b1, 1'b0);
    mode = 2'b00;
    duty = 4'h9;
    step(1);
    chk("R6", 1'b0, 1'b0);
    pwm_in = 1'b0;
    step(DEAD + 3);
    chk("R6", 1'b0, 1'b0);
    mode = 2'b10;
    step(DEAD);
    chk("R9", 1'b0, 1'b0);
    step(1);
    chk("R9", 1'b0, 1'b1);
  endtask

  task automatic t_dc();
    mode = 2'b01;
    duty = 4'h3;
    settle_low();
    chk("R7", 1'b0, 1'b1);
    pwm_in = 1'b1;
    step(DEAD + 1);
    chk("R7", 1'b1, 1'b0);
    duty = 4'h0;
    step(1);
    chk("R7", 1'b0, 1'b0);
    pwm_in = 1'b0;
    step(DEAD + 3);
    chk("R7", 1'b0, 1'b0);
    pwm_in = 1'b1;
    step(3);
    duty = 4'h8;
    step(DEAD);
    chk("R9", 1'b0, 1'b0);
    step(1);
    chk("R9", 1'b1, 1'b0);
  endtask

  task automatic t_ac_test();
    for (int m = 2; m < 4; m++) begin
      mode = m[1:0];
      duty = 4'h0;
      settle_low();
      chk("R8", 1'b0, 1'b1);
      pwm_in = 1'b1;
      step(DEAD);
      chk("R8", 1'b0, 1'b0);
      step(1);
      chk("R8", 1'b1, 1'b0);
    end
  endtask

  task automatic t_reset_mid();
    pwm_in = 1'b1;
    step(DEAD + 2);
    rst_n = 1'b0;
    step(1);
    chk("R1", 1'b0, 1'b0);
    rst_n = 1'b1;
    step(DEAD);
    chk("R1", 1'b0, 1'b0);
    step(1);
    chk("R2", 1'b1, 1'b0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_hi_edge();
    t_short_pulse();
    t_no_overlap();
    t_idle();
    t_dc();
    t_ac_test();
    t_reset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule